// File: doc/BRIEF.md
# Byte Compare-and-Scan Engine

This block walks a region of byte-wide memory looking for a byte equal to an 8-bit reference value. The reference, a 16-bit pointer, a 16-bit count and a carry bit are captured when `start` is pulsed. Each iteration lowers the count by one, reads the byte at the pointer through a single-port read interface, compares it with the reference, and then steps the pointer up or down by one.

In single-step mode the engine performs exactly one iteration. In repeating mode it keeps iterating until the byte matches or the count reaches zero. An interrupt request seen after an iteration that would otherwise continue makes the engine stop early. The pointer and count outputs then hold the state needed to carry on later. Every compare refreshes a flag byte built as reference minus byte. A cycle-cost total is kept in the units of the host processor: a per-iteration charge, an exit charge, and a flat single-step charge.

Top module: `blk_search_engine`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd`, `match`, `suspended`, `flags`, `ptr_o`, `cnt_o` and `cycles` are all zero.
- R2: Every iteration decrements the count by one, modulo 2^16, and then issues exactly one memory read at the current pointer. A run therefore performs as many reads as it has iterations.
- R3: After each compare the pointer moves by +1 when `dir_down` is 0 and by -1 when it is 1, wrapping modulo 2^16.
- R4: After each compare the flags are set from diff = reference - byte and from the count after its decrement. Bit 7 is diff[7]. Bit 6 is 1 when the byte equals the reference. Bit 4 is 1 when the low nibble of the reference is below the low nibble of the byte. Bit 2 is 1 when the count is nonzero. Bit 1 is always 1. Bits 5 and 3 are 0.
- R5: Flag bit 0 always equals the `carry_in` value captured at `start`; the operation never alters carry.
- R6: With `repeat_mode` = 0 the engine performs one iteration, `match` reports that iteration's equality, and `cycles` ends at 16.
- R7: With `repeat_mode` = 1 the engine stops after the first iteration whose byte matches or whose count reaches zero. `cycles` then ends at 21 per iteration plus 16.
- R8: A count of zero at `start` decrements to 0xFFFF, so a single step leaves `cnt_o` = 0xFFFF and flag bit 2 set.
- R9: In repeating mode, `irq_pending` high after an iteration that would not end the loop stops the engine with `suspended` = 1, no exit charge (21 per iteration only), and pointer and count as they stand. On an iteration that ends the loop anyway, `irq_pending` has no effect.
- R10: `busy` rises the cycle after an accepted `start`. `done` is a one-cycle pulse at the end of the run. `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| repeat_mode | input | 1 | 1 = repeat until match or count zero, 0 = single step |
| dir_down | input | 1 | 1 = pointer decrements, 0 = increments |
| carry_in | input | 1 | Carry flag to preserve in flag bit 0 |
| acc_in | input | 8 | Reference byte |
| ptr_in | input | 16 | Start address |
| cnt_in | input | 16 | Start count |
| irq_pending | input | 1 | Interrupt request sampled after each iteration |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid RD_LATENCY cycles after the strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| match | output | 1 | Last compared byte equalled the reference |
| suspended | output | 1 | Run stopped early on an interrupt |
| flags | output | 8 | Flag byte of the last compare |
| ptr_o | output | 16 | Current pointer |
| cnt_o | output | 16 | Current count |
| cycles | output | 32 | Accumulated cycle cost of the run |

## Verification
The bench scans a memory whose byte equals its low address bits, so every match position can be predicted. It covers a match after several steps, exhaustion of the count without a match, a match on the very first iteration with the count also reaching zero, downward scans that cross address zero, and a single step from a zero count. A design that tests the count before decrementing it would report a wrong count and a wrong bit 2. A design that stops only on a match would keep running past zero. A swapped charge order would give the wrong cycle total. The interrupt cases check that an early stop leaves out the exit charge, and that a loop which finishes on the same iteration does not report a suspension. A mid-run `start` carrying different operands must leave the results unchanged.

// File: rtl/blk_search_pkg.sv
package blk_search_pkg;
   localparam int FLG_C  = 0;
   localparam int FLG_N  = 1;
   localparam int FLG_PV = 2;
   localparam int FLG_U3 = 3;
   localparam int FLG_H  = 4;
   localparam int FLG_U5 = 5;
   localparam int FLG_Z  = 6;
   localparam int FLG_S  = 7;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ISSUE = 2'd1,
      SEQ_WAIT  = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic rep;
      logic down;
      logic carry;
   } run_cfg_t;
endpackage

// File: rtl/blk_search_rdtrack.sv
module blk_search_rdtrack #(
   parameter int LATENCY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic valid
);
   if (LATENCY < 1) begin : g_bad_latency
      $error("blk_search_rdtrack: LATENCY must be at least 1");
   end

   if (LATENCY == 1) begin : g_single
      logic v_q;
      always_ff @(posedge clk) begin
         if (!rst_n) v_q <= 1'b0;
         else        v_q <= req;
      end
      assign valid = v_q;
   end else begin : g_shift
      logic [LATENCY-1:0] sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[LATENCY-2:0], req};
      end
      assign valid = sh_q[LATENCY-1];
   end
endmodule

// File: rtl/blk_search_cmp.sv
module blk_search_cmp
   import blk_search_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic [DATA_W-1:0] ref_val,
   input  logic [DATA_W-1:0] mem_byte,
   input  logic [CNT_W-1:0]  cnt_after,
   input  logic              carry,
   output logic [7:0]        flg,
   output logic              equal
);
   localparam int NIB = 4;

   if (DATA_W < NIB) begin : g_bad_width
      $error("blk_search_cmp: DATA_W must be at least 4");
   end

   logic [DATA_W-1:0] diff;
   logic              nib_borrow;

   always_comb begin
      diff       = ref_val - mem_byte;
      equal      = (ref_val == mem_byte);
      nib_borrow = (ref_val[NIB-1:0] < mem_byte[NIB-1:0]);
      flg        = '0;
      flg[FLG_S]  = diff[DATA_W-1];
      flg[FLG_Z]  = equal;
      flg[FLG_H]  = nib_borrow;
      flg[FLG_PV] = |cnt_after;
      flg[FLG_N]  = 1'b1;
      flg[FLG_C]  = carry;
   end
endmodule

// File: rtl/blk_search_cost.sv
module blk_search_cost #(
   parameter int CYC_W     = 32,
   parameter int ITER_COST = 21,
   parameter int EXIT_COST = 16,
   parameter int STEP_COST = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             charge_iter,
   input  logic             charge_exit,
   input  logic             charge_step,
   output logic [CYC_W-1:0] total
);
   localparam logic [CYC_W-1:0] C_ITER = CYC_W'(ITER_COST);
   localparam logic [CYC_W-1:0] C_EXIT = CYC_W'(EXIT_COST);
   localparam logic [CYC_W-1:0] C_STEP = CYC_W'(STEP_COST);

   if (CYC_W < 8) begin : g_bad_width
      $error("blk_search_cost: CYC_W too narrow");
   end

   logic [CYC_W-1:0] sum_q;
   logic [CYC_W-1:0] add;

   always_comb begin
      add = '0;
      if (charge_iter) add = add + C_ITER;
      if (charge_exit) add = add + C_EXIT;
      if (charge_step) add = add + C_STEP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     sum_q <= '0;
      else if (clear) sum_q <= '0;
      else            sum_q <= sum_q + add;
   end

   assign total = sum_q;
endmodule

// File: rtl/blk_search_engine.sv
module blk_search_engine
   import blk_search_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter int CYC_W      = 32,
   parameter int RD_LATENCY = 1,
   parameter int ITER_COST  = 21,
   parameter int EXIT_COST  = 16,
   parameter int STEP_COST  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              repeat_mode,
   input  logic              dir_down,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [ADDR_W-1:0] ptr_in,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic              irq_pending,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              match,
   output logic              suspended,
   output logic [7:0]        flags,
   output logic [ADDR_W-1:0] ptr_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CYC_W-1:0]  cycles
);
   localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

   if (ADDR_W < 2 || CNT_W < 2) begin : g_bad_dims
      $error("blk_search_engine: ADDR_W and CNT_W must be at least 2");
   end
   if (ITER_COST < 0 || EXIT_COST < 0 || STEP_COST < 0) begin : g_bad_cost
      $error("blk_search_engine: costs must be non-negative");
   end

   seq_state_t        state_q;
   run_cfg_t          cfg_q;
   logic [DATA_W-1:0] acc_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [7:0]        flags_q;
   logic              match_q;
   logic              susp_q;
   logic              done_q;

   logic              accept;
   logic              issue;
   logic              rd_valid;
   logic              cmp_now;
   logic [7:0]        cmp_flags;
   logic              cmp_equal;
   logic [ADDR_W-1:0] ptr_step;
   logic              loop_over;
   logic              take_irq;
   logic              end_run;

   assign accept  = (state_q == SEQ_IDLE) && start;
   assign issue   = (state_q == SEQ_ISSUE);
   assign cmp_now = (state_q == SEQ_WAIT) && rd_valid;

   blk_search_rdtrack #(
      .LATENCY (RD_LATENCY)
   ) u_rdtrack (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (issue),
      .valid (rd_valid)
   );

   blk_search_cmp #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_cmp (
      .ref_val   (acc_q),
      .mem_byte  (mem_rdata),
      .cnt_after (cnt_q),
      .carry     (cfg_q.carry),
      .flg       (cmp_flags),
      .equal     (cmp_equal)
   );

   blk_search_cost #(
      .CYC_W     (CYC_W),
      .ITER_COST (ITER_COST),
      .EXIT_COST (EXIT_COST),
      .STEP_COST (STEP_COST)
   ) u_cost (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (accept),
      .charge_iter (cmp_now && cfg_q.rep),
      .charge_exit (cmp_now && cfg_q.rep && loop_over),
      .charge_step (cmp_now && !cfg_q.rep),
      .total       (cycles)
   );

   always_comb begin
      ptr_step  = cfg_q.down ? (ptr_q - PTR_ONE) : (ptr_q + PTR_ONE);
      loop_over = cmp_equal || (cnt_q == '0);
      take_irq  = cfg_q.rep && !loop_over && irq_pending;
      end_run   = !cfg_q.rep || loop_over || take_irq;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cfg_q   <= '0;
         acc_q   <= '0;
         ptr_q   <= '0;
         cnt_q   <= '0;
         flags_q <= '0;
         match_q <= 1'b0;
         susp_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  cfg_q.rep   <= repeat_mode;
                  cfg_q.down  <= dir_down;
                  cfg_q.carry <= carry_in;
                  acc_q       <= acc_in;
                  ptr_q       <= ptr_in;
                  cnt_q       <= cnt_in;
                  match_q     <= 1'b0;
                  susp_q      <= 1'b0;
                  state_q     <= SEQ_ISSUE;
               end
            end
            SEQ_ISSUE: begin
               cnt_q   <= cnt_q - CNT_ONE;
               state_q <= SEQ_WAIT;
            end
            SEQ_WAIT: begin
               if (rd_valid) begin
                  flags_q <= cmp_flags;
                  match_q <= cmp_equal;
                  ptr_q   <= ptr_step;
                  if (end_run) begin
                     susp_q  <= take_irq;
                     done_q  <= 1'b1;
                     state_q <= SEQ_IDLE;
                  end else begin
                     state_q <= SEQ_ISSUE;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign mem_rd    = issue;
   assign mem_addr  = ptr_q;
   assign busy      = (state_q != SEQ_IDLE);
   assign done      = done_q;
   assign match     = match_q;
   assign suspended = susp_q;
   assign flags     = flags_q;
   assign ptr_o     = ptr_q;
   assign cnt_o     = cnt_q;
endmodule

// File: rtl/blk_search_engine_chk.sv
module blk_search_engine_chk #(
   parameter int CNT_W     = 16,
   parameter int CYC_W     = 32,
   parameter int ITER_COST = 21,
   parameter int EXIT_COST = 16,
   parameter int STEP_COST = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             repeat_mode,
   input logic             carry_in,
   input logic [CNT_W-1:0] cnt_in,
   input logic             mem_rd,
   input logic             busy,
   input logic             done,
   input logic             suspended,
   input logic [7:0]       flags,
   input logic [CNT_W-1:0] cnt_o,
   input logic [CYC_W-1:0] cycles
);
   logic             carry_l;
   logic             rep_l;
   logic [CNT_W-1:0] cnt_l;
   logic [CNT_W-1:0] iters;
   logic [CYC_W-1:0] loop_cost;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_l <= 1'b0;
         rep_l   <= 1'b0;
         cnt_l   <= '0;
      end else if (start && !busy) begin
         carry_l <= carry_in;
         rep_l   <= repeat_mode;
         cnt_l   <= cnt_in;
      end
   end

   always_comb begin
      iters     = cnt_l - cnt_o;
      loop_cost = CYC_W'(iters) * CYC_W'(ITER_COST);
   end

   assert_read_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);

   assert_flag_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags[1] && !flags[5] && !flags[3]));

   assert_pv_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags[2] == (cnt_o != '0)));

   assert_carry_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags[0] == carry_l));

   assert_step_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rep_l) |-> (cycles == CYC_W'(STEP_COST)));

   assert_loop_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rep_l && !suspended) |-> (cycles == loop_cost + CYC_W'(EXIT_COST)));

   assert_loop_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rep_l && !suspended && !flags[6]) |-> (cnt_o == '0));

   assert_yield_cost_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && suspended) |-> (rep_l && cycles == loop_cost && cnt_o != '0));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind blk_search_engine blk_search_engine_chk #(
   .CNT_W     (CNT_W),
   .CYC_W     (CYC_W),
   .ITER_COST (ITER_COST),
   .EXIT_COST (EXIT_COST),
   .STEP_COST (STEP_COST)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .repeat_mode (repeat_mode),
   .carry_in    (carry_in),
   .cnt_in      (cnt_in),
   .mem_rd      (mem_rd),
   .busy        (busy),
   .done        (done),
   .suspended   (suspended),
   .flags       (flags),
   .cnt_o       (cnt_o),
   .cycles      (cycles)
);

// File: tb/test_blk_search_engine.sv
module test_blk_search_engine;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        repeat_mode = 1'b0;
   logic        dir_down = 1'b0;
   logic        carry_in = 1'b0;
   logic [7:0]  acc_in = '0;
   logic [15:0] ptr_in = '0;
   logic [15:0] cnt_in = '0;
   logic        irq_pending = 1'b0;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic        busy, done, match, suspended;
   logic [7:0]  flags;
   logic [15:0] ptr_o, cnt_o;
   logic [31:0] cycles;

   int errors = 0;
   int checks = 0;
   int reads  = 0;
   int cyc_count = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   blk_search_engine i_blk_search_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .repeat_mode(repeat_mode),
      .dir_down(dir_down), .carry_in(carry_in), .acc_in(acc_in),
      .ptr_in(ptr_in), .cnt_in(cnt_in), .irq_pending(irq_pending),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .match(match), .suspended(suspended),
      .flags(flags), .ptr_o(ptr_o), .cnt_o(cnt_o), .cycles(cycles)
   );

   // Memory model: each byte equals the low eight address bits, latency 1.
   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= mem_addr[7:0];
         reads     <= reads + 1;
      end
   end

   always @(posedge clk) cyc_count <= cyc_count + 1;

   initial begin
      wait (cyc_count >= WATCHDOG);
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cyc_count, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic launch(input logic rep, input logic down, input logic cy,
                         input logic [7:0] acc, input logic [15:0] ptr,
                         input logic [15:0] cnt, input logic irq);
      @(negedge clk);
      repeat_mode = rep; dir_down = down; carry_in = cy;
      acc_in = acc; ptr_in = ptr; cnt_in = cnt; irq_pending = irq;
      reads = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      if (!done) check("R10", "done never pulsed", 0, 1);
   endtask

   typedef struct packed {
      logic        rep;
      logic        down;
      logic        carry;
      logic [7:0]  acc;
      logic [15:0] ptr;
      logic [15:0] cnt;
      logic [15:0] e_ptr;
      logic [15:0] e_cnt;
      logic [7:0]  e_flags;
      logic        e_match;
      logic [15:0] e_cyc;
      logic [15:0] e_reads;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      // repeat up, match after nine reads
      '{1'b1, 1'b0, 1'b1, 8'h10, 16'h0008, 16'h0020, 16'h0011, 16'h0017, 8'h47, 1'b1, 16'd205, 16'd9},
      // repeat up, count runs out first
      '{1'b1, 1'b0, 1'b0, 8'h10, 16'h0008, 16'h0004, 16'h000C, 16'h0000, 8'h12, 1'b0, 16'd100, 16'd4},
      // repeat down, match after six reads
      '{1'b1, 1'b1, 1'b1, 8'h03, 16'h0008, 16'h0010, 16'h0002, 16'h000A, 8'h47, 1'b1, 16'd142, 16'd6},
      // single up, negative difference, count to zero
      '{1'b0, 1'b0, 1'b0, 8'h20, 16'h0030, 16'h0001, 16'h0031, 16'h0000, 8'h82, 1'b0, 16'd16, 16'd1},
      // single down from zero count: wraps (R8)
      '{1'b0, 1'b1, 1'b1, 8'h45, 16'h0045, 16'h0000, 16'h0044, 16'hFFFF, 8'h47, 1'b1, 16'd16, 16'd1},
      // repeat, match and zero count on first iteration
      '{1'b1, 1'b0, 1'b0, 8'h07, 16'h0007, 16'h0001, 16'h0008, 16'h0000, 8'h42, 1'b1, 16'd37, 16'd1},
      // single down across address zero
      '{1'b0, 1'b1, 1'b1, 8'h99, 16'h0000, 16'h0005, 16'hFFFF, 16'h0004, 8'h87, 1'b0, 16'd16, 16'd1},
      // repeat down across address zero, match at 0xFFFE
      '{1'b1, 1'b1, 1'b0, 8'hFE, 16'h0001, 16'h0005, 16'hFFFD, 16'h0001, 8'h46, 1'b1, 16'd100, 16'd4}
   };

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "busy",   32'(busy), 0);
      check("R1", "done",   32'(done), 0);
      check("R1", "mem_rd", 32'(mem_rd), 0);
      check("R1", "flags",  32'(flags), 0);
      check("R1", "ptr_o",  32'(ptr_o), 0);
      check("R1", "cycles", cycles, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         vec_t v = VECS[i];
         launch(v.rep, v.down, v.carry, v.acc, v.ptr, v.cnt, 1'b0);
         check("R10", "busy after start", 32'(busy), 1);
         wait_done();
         check("R3", "pointer", 32'(ptr_o), 32'(v.e_ptr));
         check((v.cnt == 16'h0) ? "R8" : "R2", "count", 32'(cnt_o), 32'(v.e_cnt));
         check("R4", "flags", 32'(flags[7:1]), 32'(v.e_flags[7:1]));
         check("R5", "carry kept", 32'(flags[0]), 32'(v.carry));
         check(v.rep ? "R7" : "R6", "match", 32'(match), 32'(v.e_match));
         check(v.rep ? "R7" : "R6", "cycles", cycles, 32'(v.e_cyc));
         check("R2", "read count", 32'(reads), 32'(v.e_reads));
         @(negedge clk);
         check("R10", "done one cycle", 32'(done), 0);
      end

      // R9: interrupt stops a continuing loop after one iteration
      launch(1'b1, 1'b0, 1'b1, 8'hEE, 16'h0040, 16'h0010, 1'b1);
      wait_done();
      check("R9", "suspended", 32'(suspended), 1);
      check("R9", "pointer", 32'(ptr_o), 32'h0041);
      check("R9", "count", 32'(cnt_o), 32'h000F);
      check("R9", "flags", 32'(flags), 32'h87);
      check("R9", "cycles no exit", cycles, 21);
      check("R9", "reads", 32'(reads), 1);

      // R9: interrupt has no effect when the loop ends on that iteration
      launch(1'b1, 1'b0, 1'b0, 8'h41, 16'h0041, 16'h0008, 1'b1);
      wait_done();
      check("R9", "not suspended", 32'(suspended), 0);
      check("R9", "match", 32'(match), 1);
      check("R9", "cycles with exit", cycles, 37);
      irq_pending = 1'b0;

      // R10: start while busy is ignored
      launch(1'b1, 1'b0, 1'b1, 8'h10, 16'h0008, 16'h0020, 1'b0);
      @(negedge clk);
      start = 1'b1; acc_in = 8'h08; ptr_in = 16'h0000; cnt_in = 16'h0003;
      repeat_mode = 1'b0; dir_down = 1'b1; carry_in = 1'b0;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check("R10", "ignored start ptr", 32'(ptr_o), 32'h0011);
      check("R10", "ignored start cnt", 32'(cnt_o), 32'h0017);
      check("R10", "ignored start cycles", cycles, 205);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule